// File: doc/BRIEF.md
# Two-Address Memory-to-Memory Add Sequencer

This block carries out one two-operand add instruction, memory to memory, within a single instruction cycle. On a start request it fetches an instruction word from the address given by the supplied program counter value. It then reads the word at operand address A into one holding register and the word at operand address B into a second holding register. It adds the two values and writes the sum back to address A. Every access goes through one synchronous memory port, and each state of the sequencer issues at most one access.

A host places the instruction and its operands in memory, presents the program counter value and pulses start. It then waits for the one-cycle done pulse, after which the sequencer is idle again and accepts the next start. Because the sum overwrites address A, a chain of such instructions can accumulate values in place.

Top module: `m2m_add_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, mem_rd and mem_wr are all 0.
- R2: The instruction word is 24 bits: bits 23..20 are an opcode, bits 19..10 are address A and bits 9..0 are address B. The opcode field is not decoded, so every opcode value gives the same accesses and the same result.
- R3: When start is high while the block is idle, the next cycle drives mem_rd=1 with mem_addr equal to the pc value sampled with start.
- R4: The accesses follow a fixed order, one cycle apart where shown: fetch (cycle 1), no access (cycle 2), read A (cycle 3), read B (cycle 4), no access (cycle 5), write A (cycle 6). Cycles count from the clock edge that accepted start. mem_rd and mem_wr are never high together.
- R5: Read data is taken from mem_rdata one cycle after mem_rd was asserted. Operands use bits 15..0 of the word, and bits 23..16 of an operand word have no effect.
- R6: The written value is (value at A + value at B) modulo 2^16, with the carry discarded, and mem_wdata bits 23..16 are 0.
- R7: The first operand stays held while the second is read. When A equals B the written value is twice the original value, and the write comes after both reads.
- R8: done is high for exactly one cycle, the cycle after the write (cycle 7). busy is high from cycle 1 through cycle 7 and low afterwards.
- R9: start while busy is ignored: no extra fetch follows, and the block is idle after done.
- R10: Back-to-back instructions see the result written by the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one instruction when idle |
| pc | input | 10 | Address of the instruction word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 10 | Memory address |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 24 | Write data, sum in bits 15..0 |
| mem_rdata | input | 24 | Read data, valid one cycle after mem_rd |

## Verification
The hardest case to reach from the ports is the one where both operand addresses are the same. There the second read must return the value the first read already captured, and the write must not land until both reads have finished. The bench builds instructions with A equal to B and checks the doubled result and the cycle position of the write. It also raises start in the middle of an instruction to check that the request is dropped. Operand words carry nonzero upper bits, and one operand pair wraps past 16 bits, so that the masking and the dropped carry are both visible in the written word.

// File: rtl/m2m_add_pkg.sv
package m2m_add_pkg;
    parameter int ADDR_W = 10;
    parameter int DATA_W = 16;
    parameter int OPC_W  = 4;
    localparam int WORD_W = OPC_W + 2 * ADDR_W;
    localparam int PAD_W  = WORD_W - DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        addr_t            src_a;
        addr_t            src_b;
    } instr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_RDA, S_RDB, S_ADD, S_WRITE, S_FINISH
    } state_t;

    typedef enum logic [1:0] { SEL_PC, SEL_A, SEL_B } addr_sel_t;

    typedef struct packed {
        logic      rd;
        logic      wr;
        addr_sel_t sel;
        logic      ld_ir;
        logic      ld_opa;
        logic      ld_opb;
    } ctrl_t;

    function automatic data_t wrap_add(input data_t x, input data_t y);
        return x + y;
    endfunction

    function automatic word_t pad_word(input data_t d);
        return {{PAD_W{1'b0}}, d};
    endfunction
endpackage

// File: rtl/m2m_add_ctrl.sv
module m2m_add_ctrl
    import m2m_add_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_t ctl,
    output logic  accept,
    output logic  busy,
    output logic  done
);
    state_t st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        ctl     = '0;
        ctl.sel = SEL_PC;
        nxt     = st;
        case (st)
            S_IDLE:   if (start) nxt = S_FETCH;
            S_FETCH:  begin ctl.rd = 1'b1; ctl.sel = SEL_PC; nxt = S_DECODE; end
            S_DECODE: begin ctl.ld_ir = 1'b1; nxt = S_RDA; end
            S_RDA:    begin ctl.rd = 1'b1; ctl.sel = SEL_A; nxt = S_RDB; end
            S_RDB:    begin ctl.rd = 1'b1; ctl.sel = SEL_B; ctl.ld_opa = 1'b1; nxt = S_ADD; end
            S_ADD:    begin ctl.ld_opb = 1'b1; nxt = S_WRITE; end
            S_WRITE:  begin ctl.wr = 1'b1; ctl.sel = SEL_A; nxt = S_FINISH; end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    assign accept = (st == S_IDLE) && start;
    assign busy   = (st != S_IDLE);
    assign done   = (st == S_FINISH);

    // R4: one access per cycle
    p_single_access_r4: assert property (@(posedge clk) disable iff (rst)
        !(ctl.rd && ctl.wr));
    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9: no new fetch right after done
    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

// File: rtl/m2m_add_dpath.sv
module m2m_add_dpath
    import m2m_add_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    input  logic  accept,
    input  addr_t pc,
    input  word_t rdata,
    output addr_t addr,
    output word_t wdata
);
    addr_t  pc_q;
    instr_t ir;
    data_t  opa, opb;
    data_t  sum;
    logic   unused_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir   <= '0;
            opa  <= '0;
            opb  <= '0;
        end else begin
            if (accept)     pc_q <= pc;
            if (ctl.ld_ir)  ir   <= instr_t'(rdata);
            if (ctl.ld_opa) opa  <= rdata[DATA_W-1:0];
            if (ctl.ld_opb) opb  <= rdata[DATA_W-1:0];
        end
    end

    always_comb begin
        case (ctl.sel)
            SEL_A:   addr = ir.src_a;
            SEL_B:   addr = ir.src_b;
            default: addr = pc_q;
        endcase
    end

    assign sum         = wrap_add(opa, opb);
    assign wdata       = pad_word(sum);
    assign unused_bits = ^{ir.opc, ctl.rd};

    // R7: first operand held while the second arrives
    p_opa_held_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |-> $stable(opa));
    // R6: upper write bits are zero
    p_wdata_pad_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |-> (wdata[WORD_W-1:DATA_W] == '0));
endmodule

// File: rtl/m2m_add_seq.sv
module m2m_add_seq
    import m2m_add_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    pc,
    output logic                 busy,
    output logic                 done,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata
);
    ctrl_t ctl;
    logic  accept;

    m2m_add_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ctl    (ctl),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    m2m_add_dpath u_dpath (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .accept (accept),
        .pc     (pc),
        .rdata  (mem_rdata),
        .addr   (mem_addr),
        .wdata  (mem_wdata)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;

    // R3: fetch from the sampled pc right after an accepted start
    p_fetch_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (mem_rd && mem_addr == $past(pc)));
    // R8: done follows the write
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> done);
endmodule

// File: tb/m2m_add_seq_tb.sv
`timescale 1ns/1ps
module m2m_add_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [9:0]  pc = '0;
    logic        busy, done, mem_rd, mem_wr;
    logic [9:0]  mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic [23:0] mem [0:1023];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    m2m_add_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .pc(pc),
        .busy(busy), .done(done), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_outs(input string req);
        chk(!busy, req, "busy", 32'(busy), 0);
        chk(!done, req, "done", 32'(done), 0);
        chk(!mem_rd, req, "mem_rd", 32'(mem_rd), 0);
        chk(!mem_wr, req, "mem_wr", 32'(mem_wr), 0);
    endtask

    task automatic t_reset();
        @(negedge clk); idle_outs("R1");
        rst = 1'b0;
        @(negedge clk); idle_outs("R1");
    endtask

    // One instruction, checked cycle by cycle
    task automatic run_add(input logic [9:0] pc_v, input logic [9:0] a_v,
                           input logic [9:0] b_v, input logic [3:0] opc,
                           input bit init, input logic [15:0] va,
                           input logic [15:0] vb, input logic [7:0] hi,
                           input bit poke);
        logic [15:0] oa, ob, expv;
        mem[pc_v] = {opc, a_v, b_v};
        if (init) begin
            mem[a_v] = {hi, va};
            if (a_v != b_v) mem[b_v] = {hi, vb};
        end
        oa = mem[a_v][15:0];
        ob = mem[b_v][15:0];
        expv = oa + ob;
        @(negedge clk); pc = pc_v; start = 1'b1;
        @(negedge clk); start = 1'b0; pc = ~pc_v;
        // cycle 1
        chk(mem_rd && !mem_wr, "R3", "fetch rd", 32'(mem_rd), 1);
        chk(mem_addr == pc_v, "R3", "fetch addr", 32'(mem_addr), 32'(pc_v));
        chk(busy && !done, "R8", "busy c1", 32'(busy), 1);
        @(negedge clk); // cycle 2
        chk(!mem_rd && !mem_wr, "R4", "idle c2", 32'({mem_rd, mem_wr}), 0);
        @(negedge clk); // cycle 3
        if (poke) start = 1'b1;
        chk(mem_rd && !mem_wr && mem_addr == a_v, "R4", "read A",
            32'({mem_rd, mem_wr, mem_addr}), 32'({2'b10, a_v}));
        @(negedge clk); // cycle 4
        start = 1'b0;
        chk(mem_rd && !mem_wr && mem_addr == b_v, "R4", "read B",
            32'({mem_rd, mem_wr, mem_addr}), 32'({2'b10, b_v}));
        @(negedge clk); // cycle 5
        chk(!mem_rd && !mem_wr && !done, "R4", "idle c5",
            32'({mem_rd, mem_wr, done}), 0);
        @(negedge clk); // cycle 6
        chk(mem_wr && !mem_rd && mem_addr == a_v, "R7", "write A",
            32'({mem_rd, mem_wr, mem_addr}), 32'({2'b01, a_v}));
        chk(mem_wdata == {8'h00, expv}, "R6", "wdata", 32'(mem_wdata),
            32'({8'h00, expv}));
        chk(!done, "R8", "done early", 32'(done), 0);
        @(negedge clk); // cycle 7
        chk(done && busy, "R8", "done pulse", 32'({done, busy}), 3);
        chk(!mem_rd && !mem_wr, "R4", "idle c7", 32'({mem_rd, mem_wr}), 0);
        @(negedge clk); // cycle 8
        idle_outs(poke ? "R9" : "R8");
        @(negedge clk); // cycle 9
        idle_outs(poke ? "R9" : "R8");
        chk(mem[a_v][15:0] == expv, "R6", "stored sum", 32'(mem[a_v]),
            32'(expv));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (2) @(negedge clk);
        t_reset();
        // R6: plain sum, upper bits of operand words ignored (R5)
        run_add(10'h010, 10'h100, 10'h101, 4'h5, 1, 16'h1234, 16'h0F0F, 8'hAB, 0);
        // R6: carry discarded
        run_add(10'h020, 10'h200, 10'h201, 4'h5, 1, 16'hFFFF, 16'h0002, 8'hFF, 0);
        // R7: same address twice
        run_add(10'h030, 10'h2A0, 10'h2A0, 4'h5, 1, 16'h1234, 16'h0000, 8'h5A, 0);
        // R2: other opcode, same behaviour
        run_add(10'h040, 10'h300, 10'h301, 4'hC, 1, 16'h8000, 16'h0001, 8'h00, 0);
        // R9: start raised while busy
        run_add(10'h050, 10'h310, 10'h311, 4'h5, 1, 16'h0101, 16'h0202, 8'h11, 1);
        // R10: chain, second instruction reuses the stored sum
        run_add(10'h060, 10'h320, 10'h321, 4'h5, 1, 16'h0003, 16'h0004, 8'h00, 0);
        run_add(10'h061, 10'h320, 10'h321, 4'h5, 0, 16'h0000, 16'h0000, 8'h00, 0);
        chk(mem[10'h320][15:0] == 16'h000B, "R10", "chain result",
            32'(mem[10'h320]), 32'h000B);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule